// File: doc/BRIEF.md
# Complementary PWM Pair with Dead-Time Insertion

This block produces one channel of center-aligned pulse-width modulation for a half-bridge power stage. A signed sweep counter ramps up from minus half the period to plus half the period and back down. A signed duty word is compared against it, which gives a raw switching waveform centered on the bottom of the sweep. A duty word of zero gives exactly half of each cycle on. The raw waveform and its complement drive a high-side output and a low-side output. Both outputs are active high.

Before either output turns on, a per-side down-counter holds it off for twice the programmed dead-time value in clocks, measured from the moment the opposite output turned off. Turn-off is never delayed. The two switches of the bridge are therefore never on together. The shoot-through gap can be set from 0 to 2046 clocks.

A strobe marks the bottom of every sweep. New period and duty words take effect only there. The dead-time value is applied live.

Top module: `pwm_pair_dt`

## Requirements
- R1: While rst_n is low, and from the first clock edge at which enable is low or sync_clr is high, hi_out, lo_out and boundary_stb are all 0. Changes on duty or period during that time have no effect on the outputs.
- R2: boundary_stb is high for exactly one clock at the bottom of each sweep, and successive strobes are 4·H clocks apart, where H = floor(period/2), with H taken as 1 when floor(period/2) is 0.
- R3: For a duty value D with -H ≤ D ≤ H-1, the raw high-side waveform is high for 2·(D+H) clocks of each 4·H-clock sweep, so D = 0 gives exactly half. The raw low-side waveform is its complement.
- R4: For D ≥ H+1 the raw high-side waveform is high for the whole sweep. For D ≤ -H it is never high.
- R5: After either output deasserts, the opposite output asserts exactly 2·dead_time clocks later. Per sweep, each output is high for its raw high time minus 2·dead_time.
- R6: With dead_time = 0, exactly one of hi_out and lo_out is high on every clock once the sweep is running.
- R7: hi_out and lo_out are never high on the same clock.
- R8: A raw pulse of 2·dead_time clocks or less leaves the corresponding output low for that whole pulse.
- R9: New period and duty values are taken only at the sweep bottom that boundary_stb marks. An output keeps the waveform of the old duty value up to and including the strobe clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enable | input | 1 | Runs the sweep when high; holds everything cleared when low |
| sync_clr | input | 1 | Synchronous clear of counters and outputs |
| period | input | CNT_W | Unsigned sweep length; half of it is the sweep amplitude |
| duty | input | CNT_W | Signed duty word, 0 means 50 percent |
| dead_time | input | DT_W | Unsigned turn-on delay in units of two clocks |
| hi_out | output | 1 | High-side switch drive, active high |
| lo_out | output | 1 | Low-side switch drive, active high |
| boundary_stb | output | 1 | One-clock strobe at the bottom of each sweep |

## Verification
A wrong sweep turnaround or reload shows at once as a changed strobe spacing, so the spacing between strobes is measured for even, odd and undersized periods. A wrong comparator edge or dead-time count moves the per-sweep on-time of either output by one or more clocks within the first full sweep after the settings are latched. The bench therefore counts on-clocks, off-clocks and overlap clocks over whole sweeps, and it measures the both-off gap at each transition. An early latch of the duty word shows as the high-side output dropping before the strobe clock. A missing clear shows as a nonzero output one clock after enable falls.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;
  localparam int SIDES = 2;
  typedef enum logic [0:0] {
    SIDE_HI = 1'b0,
    SIDE_LO = 1'b1
  } side_e;
endpackage

// File: rtl/pwm_sweep_counter.sv
module pwm_sweep_counter #(
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic        [CNT_W-1:0] period,
  input  logic signed [CNT_W-1:0] duty,
  output logic signed [CNT_W-1:0] cnt,
  output logic signed [CNT_W-1:0] duty_lat,
  output logic                    up,
  output logic                    started,
  output logic                    stb
);
  localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);

  logic signed [CNT_W-1:0] cnt_q, cnt_d;
  logic signed [CNT_W-1:0] half_q, half_d;
  logic signed [CNT_W-1:0] duty_q, duty_d;
  logic                    up_q, up_d;
  logic                    started_q, started_d;
  logic signed [CNT_W-1:0] half_raw, half_new;

  // Half period from the live input, never below one.
  assign half_raw = {1'b0, period[CNT_W-1:1]};
  assign half_new = (half_raw == '0) ? ONE : half_raw;

  always_comb begin
    cnt_d     = cnt_q;
    half_d    = half_q;
    duty_d    = duty_q;
    up_d      = up_q;
    started_d = started_q;
    if (!run) begin
      cnt_d     = '0;
      half_d    = '0;
      duty_d    = '0;
      up_d      = 1'b0;
      started_d = 1'b0;
    end else if (!started_q) begin
      // First sweep starts at the bottom with fresh settings.
      started_d = 1'b1;
      cnt_d     = -half_new;
      half_d    = half_new;
      duty_d    = duty;
      up_d      = 1'b1;
    end else if (up_q) begin
      if (cnt_q == half_q) begin
        up_d  = 1'b0;
        cnt_d = cnt_q - ONE;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else begin
      if (cnt_q == (-half_q + ONE)) begin
        // Entering the bottom: the only point where settings reload.
        cnt_d  = -half_new;
        half_d = half_new;
        duty_d = duty;
        up_d   = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      half_q    <= '0;
      duty_q    <= '0;
      up_q      <= 1'b0;
      started_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      half_q    <= half_d;
      duty_q    <= duty_d;
      up_q      <= up_d;
      started_q <= started_d;
    end
  end

  assign cnt      = cnt_q;
  assign duty_lat = duty_q;
  assign up       = up_q;
  assign started  = started_q;
  assign stb      = started_q & up_q & (cnt_q == -half_q);

  // R2: the bottom lasts a single clock
  a_r2_stb_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);

  // R9: the latched duty only moves on the edge that lands on the bottom
  a_r9_latch_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$stable(duty_q)) |-> stb);

  // R2: the counter stays inside the latched amplitude
  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |-> (cnt_q <= half_q) && (cnt_q >= -half_q));
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int CNT_W = 16
) (
  input  logic                    started,
  input  logic                    up,
  input  logic signed [CNT_W-1:0] cnt,
  input  logic signed [CNT_W-1:0] duty_lat,
  output logic [pwm_dt_pkg::SIDES-1:0] raw
);
  import pwm_dt_pkg::*;

  logic cmp_hi;

  // Strict compare on the rising ramp and inclusive on the falling ramp
  // make a zero duty word cover exactly half the sweep.
  always_comb begin
    if (up) cmp_hi = (cnt < duty_lat);
    else    cmp_hi = (cnt <= duty_lat);
    raw          = '0;
    raw[SIDE_HI] = started & cmp_hi;
    raw[SIDE_LO] = started & ~cmp_hi;
  end
endmodule

// File: rtl/pwm_dt_gate.sv
module pwm_dt_gate #(
  parameter int DT_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            raw,
  input  logic [DT_W-1:0] dt_val,
  output logic            out
);
  localparam int DCNT_W = DT_W + 1;
  localparam logic [DCNT_W-1:0] DONE = DCNT_W'(1);

  logic              prev_q, prev_d;
  logic              out_q, out_d;
  logic [DCNT_W-1:0] cnt_q, cnt_d;
  logic [DCNT_W-1:0] load_val;

  assign load_val = {dt_val, 1'b0};

  always_comb begin
    prev_d = prev_q;
    out_d  = out_q;
    cnt_d  = cnt_q;
    if (!run) begin
      prev_d = 1'b0;
      out_d  = 1'b0;
      cnt_d  = '0;
    end else begin
      prev_d = raw;
      if (!raw) begin
        out_d = 1'b0;
        cnt_d = '0;
      end else if (!prev_q) begin
        if (dt_val == '0) begin
          out_d = 1'b1;
          cnt_d = '0;
        end else begin
          out_d = 1'b0;
          cnt_d = load_val;
        end
      end else if (cnt_q == DONE) begin
        out_d = 1'b1;
        cnt_d = '0;
      end else if (cnt_q != '0) begin
        cnt_d = cnt_q - DONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      out_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= prev_d;
      out_q  <= out_d;
      cnt_q  <= cnt_d;
    end
  end

  assign out = out_q;

  // R5: a turn-on happens only when the delay expires or no delay is set
  a_r5_turn_on_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> (($past(dt_val) == '0) || ($past(cnt_q) == DONE)));

  // R8: the output is never high unless the raw pulse was present
  a_r8_out_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
    out_q |-> $past(raw));
endmodule

// File: rtl/pwm_pair_dt.sv
module pwm_pair_dt #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    sync_clr,
  input  logic        [CNT_W-1:0] period,
  input  logic signed [CNT_W-1:0] duty,
  input  logic        [DT_W-1:0]  dead_time,
  output logic                    hi_out,
  output logic                    lo_out,
  output logic                    boundary_stb
);
  import pwm_dt_pkg::*;

  logic                    run;
  logic signed [CNT_W-1:0] cnt;
  logic signed [CNT_W-1:0] duty_lat;
  logic                    up;
  logic                    started;
  logic [SIDES-1:0]        raw;
  logic [SIDES-1:0]        drv;

  assign run = enable & ~sync_clr;

  pwm_sweep_counter #(.CNT_W(CNT_W)) i_sweep (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .period   (period),
    .duty     (duty),
    .cnt      (cnt),
    .duty_lat (duty_lat),
    .up       (up),
    .started  (started),
    .stb      (boundary_stb)
  );

  pwm_compare #(.CNT_W(CNT_W)) i_cmp (
    .started  (started),
    .up       (up),
    .cnt      (cnt),
    .duty_lat (duty_lat),
    .raw      (raw)
  );

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    pwm_dt_gate #(.DT_W(DT_W)) i_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .raw    (raw[g]),
      .dt_val (dead_time),
      .out    (drv[g])
    );
  end

  assign hi_out = drv[SIDE_HI];
  assign lo_out = drv[SIDE_LO];

  // R7: shoot-through never happens
  a_r7_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_out && lo_out));

  // R1: clearing drives everything low on the next clock
  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!hi_out && !lo_out && !boundary_stb));
endmodule

// File: tb/test_pwm_pair_dt.sv
module test_pwm_pair_dt;
  logic               clk = 1'b0;
  logic               rst_n;
  logic               enable;
  logic               sync_clr;
  logic        [15:0] period;
  logic signed [15:0] duty;
  logic        [9:0]  dead_time;
  logic               hi_out, lo_out, boundary_stb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pwm_pair_dt i_pwm_pair_dt (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .sync_clr     (sync_clr),
    .period       (period),
    .duty         (duty),
    .dead_time    (dead_time),
    .hi_out       (hi_out),
    .lo_out       (lo_out),
    .boundary_stb (boundary_stb)
  );

  typedef struct packed {
    logic [15:0]        per;
    logic signed [15:0] dty;
    logic [9:0]         dt;
    logic [15:0]        ehi;
    logic [15:0]        elo;
  } vec_t;

  // period, duty, dead time, expected hi clocks and lo clocks per sweep
  localparam vec_t VECS [10] = '{
    '{16'd40,  16'sd0,    10'd0,    16'd40, 16'd40},
    '{16'd40,  16'sd0,    10'd3,    16'd34, 16'd34},
    '{16'd40,  16'sd10,   10'd2,    16'd56, 16'd16},
    '{16'd40, -16'sd15,   10'd1,    16'd8,  16'd68},
    '{16'd40,  16'sd25,   10'd5,    16'd80, 16'd0},
    '{16'd40, -16'sd20,   10'd0,    16'd0,  16'd80},
    '{16'd64, -16'sd30,   10'd1,    16'd2,  16'd122},
    '{16'd64, -16'sd31,   10'd1,    16'd0,  16'd124},
    '{16'd24,  16'sd0,    10'd1023, 16'd0,  16'd0},
    '{16'd20,  16'sd5,    10'd0,    16'd30, 16'd10}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_stb();
    int n = 0;
    @(negedge clk);
    while (!boundary_stb && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measure(input int win, output int nh, output int nl, output int nb);
    nh = 0; nl = 0; nb = 0;
    for (int i = 0; i < win; i++) begin
      nh += int'(hi_out);
      nl += int'(lo_out);
      nb += int'(hi_out & lo_out);
      @(negedge clk);
    end
  endtask

  task automatic stb_gap(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!boundary_stb && n < 5000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int nh, nl, nb, gap, win;
    rst_n = 1'b0; enable = 1'b0; sync_clr = 1'b0;
    period = 16'd40; duty = 16'sd0; dead_time = 10'd0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 reset hi_out", int'(hi_out), 0);
    chk("R1 reset lo_out", int'(lo_out), 0);
    chk("R1 reset stb", int'(boundary_stb), 0);
    rst_n = 1'b1;
    @(negedge clk);
    enable = 1'b1;

    // Vector table walk: R3, R4, R5, R6, R7, R8
    for (int v = 0; v < 10; v++) begin
      period    = VECS[v].per;
      duty      = VECS[v].dty;
      dead_time = VECS[v].dt;
      wait_stb(); wait_stb(); wait_stb();
      win = 4 * int'(VECS[v].per / 2);
      measure(win, nh, nl, nb);
      chk($sformatf("R3/R4/R5/R8 vec%0d hi clocks", v), nh, int'(VECS[v].ehi));
      chk($sformatf("R3/R4/R5/R8 vec%0d lo clocks", v), nl, int'(VECS[v].elo));
      chk($sformatf("R7 vec%0d overlap clocks", v), nb, 0);
      if (VECS[v].dt == 10'd0 && VECS[v].ehi != 16'd0 && VECS[v].elo != 16'd0)
        chk($sformatf("R6 vec%0d one side always on", v), nh + nl, win);
    end

    // R2 strobe spacing: even, odd and undersized periods
    period = 16'd40; duty = 16'sd0; dead_time = 10'd0;
    wait_stb(); wait_stb();
    stb_gap(gap);
    chk("R2 spacing period 40", gap, 80);
    @(negedge clk);
    chk("R2 strobe width one clock", int'(boundary_stb), 0);
    period = 16'd41;
    wait_stb(); wait_stb();
    stb_gap(gap);
    chk("R2 spacing period 41", gap, 80);
    period = 16'd1;
    wait_stb(); wait_stb();
    stb_gap(gap);
    chk("R2 spacing period 1", gap, 4);

    // R5 gap measured at both transitions
    period = 16'd40; duty = 16'sd0; dead_time = 10'd3;
    wait_stb(); wait_stb();
    while (!hi_out) @(negedge clk);
    while (hi_out) @(negedge clk);
    gap = 0;
    while (!lo_out && gap < 500) begin gap++; @(negedge clk); end
    chk("R5 hi-off to lo-on gap", gap, 6);
    while (lo_out) @(negedge clk);
    gap = 0;
    while (!hi_out && gap < 500) begin gap++; @(negedge clk); end
    chk("R5 lo-off to hi-on gap", gap, 6);

    // R9 duty change takes effect only at the strobe
    duty = 16'sd25; dead_time = 10'd0;
    wait_stb(); wait_stb(); wait_stb();
    @(negedge clk);
    duty = -16'sd20;
    nl = 0;
    while (!boundary_stb) begin
      nl += int'(!hi_out);
      @(negedge clk);
    end
    nl += int'(!hi_out);
    chk("R9 hi held until strobe", nl, 0);
    @(negedge clk);
    chk("R9 new duty after strobe", int'(hi_out), 0);

    // R1 enable low clears and ignores new settings
    duty = 16'sd25;
    wait_stb(); wait_stb();
    chk("R1 hi active before disable", int'(hi_out), 1);
    enable = 1'b0;
    @(negedge clk);
    chk("R1 disable hi_out", int'(hi_out), 0);
    chk("R1 disable stb", int'(boundary_stb), 0);
    duty = -16'sd20; period = 16'd8;
    nh = 0;
    for (int i = 0; i < 20; i++) begin
      nh += int'(hi_out | lo_out | boundary_stb);
      @(negedge clk);
    end
    chk("R1 outputs stay low while disabled", nh, 0);

    // R1 synchronous clear
    enable = 1'b1;
    wait_stb(); wait_stb();
    sync_clr = 1'b1;
    @(negedge clk);
    chk("R1 sync_clr lo_out", int'(lo_out), 0);
    chk("R1 sync_clr stb", int'(boundary_stb), 0);
    sync_clr = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule